// File: doc/BRIEF.md
# Dual-Line SPI Flash Image Fetcher

This block copies a boot image out of a serial flash into a word-wide memory write port. On a start request it lowers chip select and sends the dual-output fast-read command together with a 24-bit flash address on the single outgoing data line. It then releases that line, gives the flash its dummy clocks, and receives two bits per SCK: one on the incoming data line and one on the line it formerly drove.

The image carries its own size. The first 32-bit word received is the length in bytes, stored low byte first. The block converts that length to a word count and streams exactly that many further words into memory at word addresses 0, 1, 2 and so on, each rearranged into little-endian order. When the last word is written it parks SCK low, raises chip select and pulses done. The SCK rate is a run-time divide of the system clock, and it is captured when the transfer starts.

Top module: `dual_spi_boot_reader`

## Requirements
- R1: While a transfer runs, chip select stays low. The first 32 SCK periods carry the byte 8'h3B and then the 24-bit address on the outgoing data line, most significant bit first. Each bit changes only while SCK is low and is stable at the rising edge. SCK is low whenever chip select is high.
- R2: Exactly 8 dummy SCK periods follow the address. The first received bit pair is sampled on the rising edge of the 41st SCK.
- R3: Each data SCK delivers two bits of the current byte, high bit first. The incoming data line carries bits 7, 5, 3, 1 and the formerly outgoing line carries bits 6, 4, 2, 0. One 32-bit word takes 16 SCK periods.
- R4: The first received word is the image length in bytes. Its first received byte is the least significant byte of the length.
- R5: The number of words written is (length + 3) / 2^2, truncated. The whole transfer uses 40 + 16 * (words + 1) SCK periods.
- R6: Data word n is written to word address n, counting from 0. In wr_data_o, bits [7:0] hold the first byte received for that word and bits [31:24] hold the last.
- R7: The flash read address sent after the command equals flash_base_i as sampled on start. The image is normally placed at 24'h010000.
- R8: SCK idles low. Its period is 2 * sck_div_i system clocks, with 0 treated as 1. The fastest rate is therefore the system clock divided by 2.
- R9: spi_mosi_oe_o goes low at the falling SCK edge that ends the 32nd command and address clock. It stays low until the transfer ends, so it is released before the first dummy clock.
- R10: After the last word, or directly after the header when the length is 0, SCK is returned low, chip select rises and done_o pulses for exactly one cycle. A length of 0 produces no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a fetch; sampled only while idle |
| flash_base_i | input | 24 | Flash byte address of the image header |
| sck_div_i | input | DIV_W | SCK half period in system clocks (0 acts as 1) |
| spi_sck_o | output | 1 | Serial clock to the flash |
| spi_cs_n_o | output | 1 | Flash chip select, active low |
| spi_mosi_o | output | 1 | Outgoing data bit for the command and address |
| spi_mosi_oe_o | output | 1 | Output enable for the outgoing data line |
| spi_mosi_i | input | 1 | Pad value of the outgoing line (even bits in dual phase) |
| spi_miso_i | input | 1 | Incoming data line (odd bits in dual phase) |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | ADDR_W | Memory word address |
| wr_data_o | output | 32 | Memory write data, little-endian |
| done_o | output | 1 | One-cycle pulse when the image has been fetched |

## Verification
The embedded assertions check several rules on every cycle. SCK stays low outside chip select and holds still whenever the clock engine is stopped. The output enable stays off in every phase after the command. Writes are separated by idle cycles and never fall outside chip select. The done pulse is a single cycle with chip select high. The bench uses a behavioural flash that captures the command and address and serves an image bit pair by bit pair. Only the bench can show the byte ordering of the length and of the data, the exact dummy count, the SCK period at each divide, the zero-length path, and how many words are written for lengths that are not a multiple of four.

// File: rtl/dspi_boot_pkg.sv
// Shared constants, phase encoding and helpers for the dual-line flash fetcher.
// Assumes 32-bit data words and the 24-bit addressing of the fast-read command.
package dspi_boot_pkg;

    localparam logic [7:0] FAST_READ_DUAL = 8'h3B;
    localparam int         HDR_BITS       = 32;   // command byte plus 24-bit address
    localparam int         DUMMY_CLKS     = 8;
    localparam int         PAIRS_PER_WORD = 16;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_DUMMY,
        PH_HDR,
        PH_DATA,
        PH_END
    } phase_t;

    // Reverse byte order of a 32-bit word (big-endian stream to little-endian)
    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/dspi_sck_gen.sv
// SCK generator: toggles SCK every half_i system clocks while run_i is high
// and flags the cycle of each rising and falling edge. Assumes half_i is held
// stable during a transfer; 0 acts as 1. SCK holds its level while stopped.
module dspi_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             sck_o,
    output logic             rise_o,
    output logic             fall_o
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff_half;
    logic             sck_q;
    logic             hit;

    // Effective half period, never zero
    always_comb begin
        eff_half = (half_i == '0) ? DIV_W'(1) : half_i;
        hit      = run_i && (cnt == eff_half - DIV_W'(1));
        rise_o   = hit && !sck_q;
        fall_o   = hit && sck_q;
    end

    // Half-period counter and SCK level register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            sck_q <= 1'b0;
        end else if (!run_i) begin
            cnt   <= '0;
        end else if (hit) begin
            cnt   <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt   <= cnt + DIV_W'(1);
        end
    end

    assign sck_o = sck_q;

    // R8: a stopped engine never moves SCK
    p_sck_hold_when_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(sck_q))
        else $error("SCK moved while stopped");

endmodule

// File: rtl/dspi_cmd_shifter.sv
// Command and address serialiser for the single-line phase. Loads the read
// command and the 24-bit address, shifts one bit per falling SCK edge and
// drops the output enable on request. Assumes shift and release come from
// the controller on falling SCK edges only.
module dspi_cmd_shifter
    import dspi_boot_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic [23:0] addr_i,
    input  logic        shift_i,
    input  logic        release_i,
    output logic        mosi_o,
    output logic        oe_o
);
    logic [HDR_BITS-1:0] sreg;
    logic                oe_q;

    // Shift register: load command/address, advance on each falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load_i) begin
            sreg <= {FAST_READ_DUAL, addr_i};
        end else if (shift_i) begin
            sreg <= {sreg[HDR_BITS-2:0], 1'b0};
        end
    end

    // Output enable: set on load, cleared when the line is handed to the flash
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (load_i) begin
            oe_q <= 1'b1;
        end else if (release_i) begin
            oe_q <= 1'b0;
        end
    end

    assign mosi_o = oe_q & sreg[HDR_BITS-1];
    assign oe_o   = oe_q;

    // R9: once released, the driver stays off until the next load
    p_oe_stays_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_q && !load_i) |=> !oe_q)
        else $error("output enable reasserted without a load");

endmodule

// File: rtl/dspi_pair_rx.sv
// Two-line receiver: on each sample strobe takes the odd bit from io1 and the
// even bit from io0, high pair first, and emits a 32-bit big-endian word every
// 16 strobes as a one-cycle valid pulse. Assumes clear_i precedes each transfer.
module dspi_pair_rx
    import dspi_boot_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear_i,
    input  logic        sample_i,
    input  logic        io1_i,
    input  logic        io0_i,
    output logic [31:0] word_o,
    output logic        valid_o
);
    localparam int PC_W = $clog2(PAIRS_PER_WORD);

    logic [29:0]   sreg;
    logic [PC_W-1:0] pair_cnt;
    logic [31:0]   word_q;
    logic          valid_q;

    // Pair accumulator and word assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg     <= '0;
            pair_cnt <= '0;
            word_q   <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (clear_i) begin
                pair_cnt <= '0;
            end else if (sample_i) begin
                sreg     <= {sreg[27:0], io1_i, io0_i};
                pair_cnt <= pair_cnt + PC_W'(1);
                if (pair_cnt == PC_W'(PAIRS_PER_WORD - 1)) begin
                    word_q  <= {sreg, io1_i, io0_i};
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign word_o  = word_q;
    assign valid_o = valid_q;

    // R3: a word is only ever completed by a sampling strobe
    p_word_from_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $past(sample_i))
        else $error("word completed without a sample");

    // R3: completed words never arrive in consecutive cycles
    p_word_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q)
        else $error("back-to-back word completions");

endmodule

// File: rtl/dual_spi_boot_reader.sv
// Dual-line SPI boot image fetcher. Sends the fast-read command and address on
// one line, counts the dummy clocks, receives a length header and then the
// image on two lines, writing little-endian words from address 0. Assumes the
// flash shifts data on falling SCK; the pad for the outgoing line is read on
// spi_mosi_i once the driver is released.
module dual_spi_boot_reader
    import dspi_boot_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [23:0]       flash_base_i,
    input  logic [DIV_W-1:0]  sck_div_i,
    output logic              spi_sck_o,
    output logic              spi_cs_n_o,
    output logic              spi_mosi_o,
    output logic              spi_mosi_oe_o,
    input  logic              spi_mosi_i,
    input  logic              spi_miso_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [31:0]       wr_data_o,
    output logic              done_o
);
    localparam int EC_W = $clog2(HDR_BITS);
    localparam int WC_W = 31;

    phase_t             phase;
    logic [DIV_W-1:0]   half_q;
    logic [EC_W-1:0]    edge_cnt;
    logic [WC_W-1:0]    remain;
    logic [ADDR_W-1:0]  idx;
    logic               cs_n_q;
    logic               wr_en_q;
    logic [ADDR_W-1:0]  wr_addr_q;
    logic [31:0]        wr_data_q;
    logic               done_q;

    logic               run;
    logic               sck;
    logic               rise;
    logic               fall;
    logic               load;
    logic               shift;
    logic               release_line;
    logic               sample;
    logic [31:0]        rx_word;
    logic               rx_valid;
    logic [31:0]        len_bytes;
    logic [WC_W-1:0]    word_count;

    // Clock engine runs in every active phase until SCK is parked low at the end
    always_comb begin
        run = (phase != PH_IDLE) && !((phase == PH_END) && !sck);
    end

    // Strobes to the shifter and receiver
    always_comb begin
        load         = (phase == PH_IDLE) && start_i;
        shift        = (phase == PH_CMD) && fall;
        release_line = shift && (edge_cnt == EC_W'(HDR_BITS - 1));
        sample       = rise && ((phase == PH_HDR) || (phase == PH_DATA));
    end

    // Length header to word count: ceil(bytes / 4)
    always_comb begin
        len_bytes  = swap32(rx_word);
        word_count = {1'b0, len_bytes[31:2]} + WC_W'(|len_bytes[1:0]);
    end

    dspi_sck_gen #(
        .DIV_W (DIV_W)
    ) u_sck (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .half_i (half_q),
        .sck_o  (sck),
        .rise_o (rise),
        .fall_o (fall)
    );

    dspi_cmd_shifter u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .addr_i    (flash_base_i),
        .shift_i   (shift),
        .release_i (release_line),
        .mosi_o    (spi_mosi_o),
        .oe_o      (spi_mosi_oe_o)
    );

    dspi_pair_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (load),
        .sample_i (sample),
        .io1_i    (spi_miso_i),
        .io0_i    (spi_mosi_i),
        .word_o   (rx_word),
        .valid_o  (rx_valid)
    );

    // Transfer sequencer: phases, clock counts, write port and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            half_q    <= DIV_W'(1);
            edge_cnt  <= '0;
            remain    <= '0;
            idx       <= '0;
            cs_n_q    <= 1'b1;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
            done_q    <= 1'b0;
        end else begin
            wr_en_q <= 1'b0;
            done_q  <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start_i) begin
                        half_q   <= sck_div_i;
                        cs_n_q   <= 1'b0;
                        edge_cnt <= '0;
                        idx      <= '0;
                        phase    <= PH_CMD;
                    end
                end
                PH_CMD: begin
                    if (fall) begin
                        if (edge_cnt == EC_W'(HDR_BITS - 1)) begin
                            edge_cnt <= '0;
                            phase    <= PH_DUMMY;
                        end else begin
                            edge_cnt <= edge_cnt + EC_W'(1);
                        end
                    end
                end
                PH_DUMMY: begin
                    if (fall) begin
                        if (edge_cnt == EC_W'(DUMMY_CLKS - 1)) begin
                            edge_cnt <= '0;
                            phase    <= PH_HDR;
                        end else begin
                            edge_cnt <= edge_cnt + EC_W'(1);
                        end
                    end
                end
                PH_HDR: begin
                    if (rx_valid) begin
                        remain <= word_count;
                        phase  <= (word_count == '0) ? PH_END : PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (rx_valid) begin
                        wr_en_q   <= 1'b1;
                        wr_addr_q <= idx;
                        wr_data_q <= swap32(rx_word);
                        idx       <= idx + ADDR_W'(1);
                        remain    <= remain - WC_W'(1);
                        if (remain == WC_W'(1)) begin
                            phase <= PH_END;
                        end
                    end
                end
                PH_END: begin
                    if (!sck) begin
                        cs_n_q <= 1'b1;
                        done_q <= 1'b1;
                        phase  <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign spi_sck_o  = sck;
    assign spi_cs_n_o = cs_n_q;
    assign wr_en_o    = wr_en_q;
    assign wr_addr_o  = wr_addr_q;
    assign wr_data_o  = wr_data_q;
    assign done_o     = done_q;

    // R1: SCK is low whenever the flash is deselected
    p_sck_low_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n_o |-> !spi_sck_o)
        else $error("SCK high with chip select released");

    // R9: the driver is off in every phase after the command
    p_line_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_DUMMY) || (phase == PH_HDR) || (phase == PH_DATA) || (phase == PH_END))
        |-> !spi_mosi_oe_o)
        else $error("outgoing line driven during receive");

    // R6: writes happen only inside a transfer and never back to back
    p_write_inside_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !spi_cs_n_o)
        else $error("write outside transfer");

    p_write_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o)
        else $error("consecutive writes");

    // R10: done is a single pulse seen with chip select high
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done longer than one cycle");

    p_done_deselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (spi_cs_n_o && !spi_sck_o))
        else $error("done while flash selected");

endmodule

// File: tb/dual_spi_boot_reader_tb.sv
`timescale 1ns/1ps
module dual_spi_boot_reader_tb;
    localparam int ADDR_W = 12;
    localparam int DIV_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [23:0]       flash_base_i = 24'h010000;
    logic [DIV_W-1:0]  sck_div_i = 8'd1;
    logic              spi_sck_o, spi_cs_n_o, spi_mosi_o, spi_mosi_oe_o;
    logic              spi_mosi_i, spi_miso_i;
    logic              wr_en_o;
    logic [ADDR_W-1:0] wr_addr_o;
    logic [31:0]       wr_data_o;
    logic              done_o;

    always #4 clk = ~clk;   // 125 MHz

    dual_spi_boot_reader #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .flash_base_i(flash_base_i),
        .sck_div_i(sck_div_i), .spi_sck_o(spi_sck_o), .spi_cs_n_o(spi_cs_n_o),
        .spi_mosi_o(spi_mosi_o), .spi_mosi_oe_o(spi_mosi_oe_o), .spi_mosi_i(spi_mosi_i),
        .spi_miso_i(spi_miso_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .done_o(done_o)
    );

    int tests = 0;
    int fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [7:0]  img [256];
    logic [31:0] m_shift = '0;
    int          m_clk = 0;
    logic [7:0]  cap_cmd = '0;
    logic [23:0] cap_addr = '0;
    logic        m_drive = 1'b0;
    logic        m_io1 = 1'b0;
    logic        m_io0 = 1'b0;
    int          contention = 0;
    int          dummy_oe = 0;

    assign spi_miso_i = m_drive ? m_io1 : 1'b0;
    assign spi_mosi_i = m_drive ? m_io0 : spi_mosi_o;

    always @(negedge spi_cs_n_o) begin
        m_clk   = 0;
        m_drive = 1'b0;
    end

    always @(posedge spi_cs_n_o) m_drive = 1'b0;

    always @(posedge spi_sck_o) begin
        if (!spi_cs_n_o) begin
            if (m_clk < 32) m_shift = {m_shift[30:0], spi_mosi_o};
            else if (spi_mosi_oe_o) dummy_oe++;
            m_clk++;
            if (m_clk == 32) begin
                cap_cmd  = m_shift[31:24];
                cap_addr = m_shift[23:0];
            end
        end
    end

    always @(negedge spi_sck_o) begin
        if (!spi_cs_n_o && m_clk >= 40) begin
            int k;
            logic [7:0] b;
            k = m_clk - 40;
            b = img[(k >> 2) & 255];
            m_drive = 1'b1;
            m_io1 = b[7 - 2 * (k % 4)];
            m_io0 = b[6 - 2 * (k % 4)];
        end
    end

    always @(negedge clk) if (m_drive && spi_mosi_oe_o) contention++;

    // ---------------- monitors ----------------
    int cyc = 0;
    int prev_rise = -1;
    int exp_half = 1;
    int per_bad = 0;
    int wr_count = 0;

    always @(posedge clk) cyc++;

    always @(posedge spi_sck_o) begin
        if (prev_rise >= 0 && (cyc - prev_rise) != 2 * exp_half) per_bad++;
        prev_rise = cyc;
    end

    function automatic logic [31:0] exp_word(input int n);
        int b;
        b = 4 + 4 * n;
        return {img[(b + 3) & 255], img[(b + 2) & 255], img[(b + 1) & 255], img[b & 255]};
    endfunction

    always @(negedge clk) begin
        if (wr_en_o) begin
            check(wr_addr_o == ADDR_W'(wr_count), "R6", "write address",
                  longint'(wr_addr_o), longint'(wr_count));
            check(wr_data_o == exp_word(wr_count), "R3/R6", "write data",
                  longint'(wr_data_o), longint'(exp_word(wr_count)));
            wr_count++;
        end
    end

    // ---------------- one fetch ----------------
    task automatic run_case(input int len, input int half, input logic [23:0] base);
        int words;
        int waited;
        words = (len + 3) / 4;
        img[0] = len[7:0];  img[1] = len[15:8];
        img[2] = len[23:16]; img[3] = len[31:24];
        for (int i = 4; i < 256; i++) img[i] = 8'($urandom);
        exp_half   = (half == 0) ? 1 : half;
        @(negedge clk);
        prev_rise  = -1;
        per_bad    = 0;
        wr_count   = 0;
        contention = 0;
        dummy_oe   = 0;
        flash_base_i = base;
        sck_div_i    = DIV_W'(half);
        start_i      = 1'b1;
        @(negedge clk);
        start_i      = 1'b0;
        waited = 0;
        while (!done_o && waited < 40000) begin
            @(negedge clk);
            waited++;
        end
        check(done_o == 1'b1, "R10", "done reached", longint'(done_o), 1);
        check(spi_cs_n_o && !spi_sck_o, "R10", "cs high, sck low at done",
              longint'({spi_cs_n_o, spi_sck_o}), 2);
        check(cap_cmd == 8'h3B, "R1", "command byte", longint'(cap_cmd), 8'h3B);
        check(cap_addr == base, "R7", "flash address", longint'(cap_addr), longint'(base));
        check(m_clk == 40 + 16 * (words + 1), "R2/R5", "SCK count",
              longint'(m_clk), longint'(40 + 16 * (words + 1)));
        check(wr_count == words, "R4/R5", "word writes", longint'(wr_count), longint'(words));
        check(per_bad == 0, "R8", "SCK period errors", longint'(per_bad), 0);
        check(contention == 0 && dummy_oe == 0, "R9", "driver released",
              longint'(contention + dummy_oe), 0);
        @(negedge clk);
        check(done_o == 1'b0, "R10", "done one cycle", longint'(done_o), 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0b07));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(spi_cs_n_o && !spi_sck_o && !spi_mosi_oe_o && !wr_en_o && !done_o,
              "R8", "reset state", longint'({spi_cs_n_o, spi_sck_o, spi_mosi_oe_o, wr_en_o, done_o}),
              5'b10000);

        run_case(0, 1, 24'h010000);   // R10: empty image
        run_case(1, 1, 24'h010000);   // R4/R5: rounds up to one word
        run_case(4, 2, 24'h010000);
        run_case(5, 1, 24'h010000);   // R5: two words
        run_case(7, 0, 24'h010000);   // R8: divide 0 acts as 1
        run_case(8, 3, 24'hA5C3F0);   // R7: other base
        for (int r = 0; r < 6; r++) begin
            run_case(1 + int'($urandom % 150), 1 + int'($urandom % 4), 24'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule